// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Register Interface

This block is the register front end for four 12-bit analog output channels. A simple bus (address, write enable, write data, read enable) loads each channel's code into a preload register. A bus read at a dedicated address then moves all four preload codes into the active registers in the same cycle, so the outputs change together. Polarity and gain for each channel come from one configuration word. That word is held in a shadow and committed to the range outputs by a read at its own address.

A control word carries an output-enable bit and a buffered-mode bit. With buffered mode off, data and configuration writes reach the active registers directly. While the enable bit is clear, every code output shows mid-scale. The converters are outside the block. It only presents the active codes, the per-channel range bits and the two control bits as ports.

Top module: `dac_quad_regif`

## Requirements
- R1: After reset every code output is 0x800, all bipolar and gain outputs are 0, and the enable and buffered outputs are 0.
- R2: In buffered mode, a write at 0x14, 0x16, 0x18 or 0x1A (channel A, B, C, D) stores write-data bits 11:0 in that channel's preload and leaves the code output unchanged. The rising edge of a read at 0x02 copies all four preloads to the active registers at that clock edge.
- R3: With buffered mode off, a data write updates the channel's active register at the same clock edge as its preload.
- R4: While enable is 0, every code output is 0x800. The active registers keep their values and appear again once enable returns to 1.
- R5: A write at 0x12 sets channel i's bipolar bit from write-data bit 7-i and its gain bit from bit 11-i (A=0 to D=3). In buffered mode this reaches the outputs only on the rising edge of a read at 0x12. Otherwise it reaches them at the write edge. Output bit i belongs to channel i.
- R6: A read held for several cycles performs its transfer once, on its first cycle. Writes made while the read is held stay in preload.
- R7: Writing 0 to the control word and then 0 to the configuration word leaves all channels unipolar, low gain and disabled, with no read needed.
- R8: A write at 0x02 sets enable from bit 1 and buffered from bit 0 and ignores the other bits. Reads at other addresses transfer nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read enable; its rising edge gives the update strobes |
| dac_code | output | 48 | Channel i code in bits 12*i+11 : 12*i |
| dac_bipolar | output | 4 | Active bipolar select, bit i for channel i |
| dac_gain_hi | output | 4 | Active gain select, bit i for channel i |
| dac_enable | output | 1 | Output enable control bit |
| dac_buffered | output | 1 | Buffered-mode control bit |

## Verification
The update path is tested with distinct codes on all four channels, so a swapped channel or a missing transfer shows at once. A read held over several cycles, with a data write inside it, separates an edge-triggered strobe from a level-triggered one. Configuration words with single bits set on different channels expose reversed or shifted bit mappings. Each path is also run with buffered mode both on and off, which separates the direct path from the staged one. A reference model in the bench checks every output on every cycle alongside these directed checks.

// File: rtl/dacq_pkg.sv
// Package: shared layout constants for the four-channel DAC register interface.
// Assumes a byte-addressed bus with 16-bit data words.
package dacq_pkg;
    localparam int unsigned CODE_W       = 12;
    localparam int unsigned NUM_CH       = 4;
    localparam int unsigned BUS_W        = 16;
    localparam int unsigned ADDR_W       = 8;
    localparam logic [7:0]  OFS_CTRL     = 8'h02;  // write: control, read: data update
    localparam logic [7:0]  OFS_CFG      = 8'h12;  // write: range shadow, read: range update
    localparam logic [7:0]  OFS_DATA0    = 8'h14;  // channel data, step of 2 bytes
    localparam int unsigned CFG_POL_TOP  = 7;      // channel 0 polarity bit
    localparam int unsigned CFG_GAIN_TOP = 11;     // channel 0 gain bit
    localparam int unsigned CTRL_EN_BIT  = 1;
    localparam int unsigned CTRL_BUF_BIT = 0;

    typedef struct packed {
        logic enable;
        logic buffered;
    } ctrl_t;
endpackage

// File: rtl/dacq_decode.sv
// Module: dacq_decode
// Decodes bus writes into per-register write selects and turns the rising
// edge of the read enable into single-cycle update strobes.
// Assumes bus_rd stays high for at least one clock per access.
module dacq_decode #(
    parameter int unsigned ADDR_W = dacq_pkg::ADDR_W,
    parameter int unsigned NUM_CH = dacq_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic              wr_ctrl,
    output logic              wr_cfg,
    output logic [NUM_CH-1:0] wr_data,
    output logic              upd_data,
    output logic              upd_cfg
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(dacq_pkg::OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(dacq_pkg::OFS_CFG);

    logic rd_q;
    logic rd_rise;

    // Remember the read enable of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= bus_rd;
    end

    assign rd_rise  = bus_rd && !rd_q;
    assign upd_data = rd_rise && (bus_addr == A_CTRL);
    assign upd_cfg  = rd_rise && (bus_addr == A_CFG);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_cfg   = bus_wr && (bus_addr == A_CFG);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_sel
            localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(dacq_pkg::OFS_DATA0 + 2 * gi);
            // Per-channel data write select.
            assign wr_data[gi] = bus_wr && (bus_addr == A_DATA);
        end
    endgenerate

    // R6: a strobe never lasts two cycles, however long the read is held.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_data || upd_cfg) |=> !(upd_data || upd_cfg));
    // R6: no strobe while the read enable was already high in the previous cycle.
    a_r6_held_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && $past(bus_rd) && $past(rst_n)) |-> !(upd_data || upd_cfg));
endmodule

// File: rtl/dacq_chan.sv
// Module: dacq_chan
// One output channel: preload register plus active register. A commit copies
// preload to active; in unbuffered mode a write loads both at once.
// Assumes the caller clips write data to CODE_W bits.
module dacq_chan #(
    parameter int unsigned CODE_W = dacq_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wdata,
    input  logic              buffered,
    input  logic              commit,
    output logic [CODE_W-1:0] active_q
);
    logic [CODE_W-1:0] preload_q;
    logic              direct;

    assign direct = wr && !buffered;

    // Preload and active registers; a direct write takes priority over a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
            active_q  <= '0;
        end else begin
            if (commit) active_q <= preload_q;
            if (wr) begin
                preload_q <= wdata;
                if (!buffered) active_q <= wdata;
            end
        end
    end

    // R2: with no commit and no direct write the active code holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !direct) |=> $stable(active_q));
    // R2: a commit delivers the preload value seen in the commit cycle.
    a_r2_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !direct) |=> (active_q == $past(preload_q)));
    // R3: an unbuffered write reaches the active code at once.
    a_r3_direct: assert property (@(posedge clk) disable iff (!rst_n)
        direct |=> (active_q == $past(wdata)));
endmodule

// File: rtl/dacq_range.sv
// Module: dacq_range
// Per-channel polarity and gain: shadow taken from the configuration word,
// active copy updated by a commit strobe or directly in unbuffered mode.
// Assumes channel i uses the channel-0 bit positions shifted right by i.
module dacq_range #(
    parameter int unsigned NUM_CH = dacq_pkg::NUM_CH,
    parameter int unsigned BUS_W  = dacq_pkg::BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              buffered,
    input  logic              commit,
    output logic [NUM_CH-1:0] pol_q,
    output logic [NUM_CH-1:0] gain_q
);
    logic [NUM_CH-1:0] pol_in, gain_in;
    logic [NUM_CH-1:0] pol_sh, gain_sh;
    logic              direct;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_field
            // Pick this channel's bits out of the configuration word.
            assign pol_in[gi]  = wdata[dacq_pkg::CFG_POL_TOP - gi];
            assign gain_in[gi] = wdata[dacq_pkg::CFG_GAIN_TOP - gi];
        end
    endgenerate

    assign direct = wr && !buffered;

    // Shadow and active range bits; a direct write takes priority over a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_sh  <= '0;
            gain_sh <= '0;
            pol_q   <= '0;
            gain_q  <= '0;
        end else begin
            if (commit) begin
                pol_q  <= pol_sh;
                gain_q <= gain_sh;
            end
            if (wr) begin
                pol_sh  <= pol_in;
                gain_sh <= gain_in;
                if (!buffered) begin
                    pol_q  <= pol_in;
                    gain_q <= gain_in;
                end
            end
        end
    end

    // R5: the active range changes only on a commit or a direct write.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !direct) |=> ($stable(pol_q) && $stable(gain_q)));
    // R5: a commit delivers the shadow seen in the commit cycle.
    a_r5_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !direct) |=> (pol_q == $past(pol_sh) && gain_q == $past(gain_sh)));
endmodule

// File: rtl/dac_quad_regif.sv
// Module: dac_quad_regif (top)
// Register interface of a four-channel DAC: control word, channel data with
// preload/active staging, and range configuration with shadow/active staging.
// Assumes a single-cycle write bus and an edge-sensed read strobe.
module dac_quad_regif #(
    parameter int unsigned CODE_W = dacq_pkg::CODE_W,
    parameter int unsigned NUM_CH = dacq_pkg::NUM_CH,
    parameter int unsigned BUS_W  = dacq_pkg::BUS_W,
    parameter int unsigned ADDR_W = dacq_pkg::ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [BUS_W-1:0]         bus_wdata,
    input  logic                     bus_rd,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        dac_bipolar,
    output logic [NUM_CH-1:0]        dac_gain_hi,
    output logic                     dac_enable,
    output logic                     dac_buffered
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

    dacq_pkg::ctrl_t   ctrl_q;
    logic              wr_ctrl, wr_cfg, upd_data, upd_cfg;
    logic [NUM_CH-1:0] wr_data;

    dacq_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .wr_ctrl  (wr_ctrl),
        .wr_cfg   (wr_cfg),
        .wr_data  (wr_data),
        .upd_data (upd_data),
        .upd_cfg  (upd_cfg)
    );

    // Control word: enable and buffered-mode bits; other bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.enable   <= bus_wdata[dacq_pkg::CTRL_EN_BIT];
            ctrl_q.buffered <= bus_wdata[dacq_pkg::CTRL_BUF_BIT];
        end
    end

    assign dac_enable   = ctrl_q.enable;
    assign dac_buffered = ctrl_q.buffered;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            logic [CODE_W-1:0] act;
            dacq_chan #(.CODE_W(CODE_W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (wr_data[gi]),
                .wdata    (bus_wdata[CODE_W-1:0]),
                .buffered (ctrl_q.buffered),
                .commit   (upd_data),
                .active_q (act)
            );
            // Mid-scale while disabled, active code otherwise.
            assign dac_code[gi*CODE_W +: CODE_W] = ctrl_q.enable ? act : MID_CODE;
        end
    endgenerate

    dacq_range #(.NUM_CH(NUM_CH), .BUS_W(BUS_W)) u_range (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cfg),
        .wdata    (bus_wdata),
        .buffered (ctrl_q.buffered),
        .commit   (upd_cfg),
        .pol_q    (dac_bipolar),
        .gain_q   (dac_gain_hi)
    );

    // R7: a zero control write leaves the block disabled and unbuffered.
    a_r7_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[1:0] == 2'b00) |=> (!dac_enable && !dac_buffered));
    // R8: the control bits move only on a control write.
    a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ($stable(dac_enable) && $stable(dac_buffered)));
endmodule

// File: tb/test_dac_quad_regif.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module test_dac_quad_regif;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [47:0] dac_code;
    logic [3:0]  dac_bipolar, dac_gain_hi;
    logic        dac_enable, dac_buffered;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state.
    int m_pre[4];
    int m_act[4];
    bit m_en, m_buf, m_rdq;
    bit m_spol[4], m_sgain[4], m_apol[4], m_again[4];

    dac_quad_regif i_dac_quad_regif (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .dac_code(dac_code),
        .dac_bipolar(dac_bipolar), .dac_gain_hi(dac_gain_hi),
        .dac_enable(dac_enable), .dac_buffered(dac_buffered)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int c);
        return int'(dac_code[c*12 +: 12]);
    endfunction

    function automatic int exp_code(input int c);
        return m_en ? m_act[c] : 32'h800;
    endfunction

    function automatic int pack4(input bit b0, input bit b1, input bit b2, input bit b3);
        return {28'd0, b3, b2, b1, b0};
    endfunction

    // Reference model advances on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_pre[c] = 0; m_act[c] = 0;
                m_spol[c] = 0; m_sgain[c] = 0; m_apol[c] = 0; m_again[c] = 0;
            end
            m_en = 0; m_buf = 0; m_rdq = 0;
        end else begin
            if (bus_rd && !m_rdq && bus_addr == 8'h02)
                for (int c = 0; c < 4; c++) m_act[c] = m_pre[c];
            if (bus_rd && !m_rdq && bus_addr == 8'h12)
                for (int c = 0; c < 4; c++) begin
                    m_apol[c] = m_spol[c]; m_again[c] = m_sgain[c];
                end
            if (bus_wr) begin
                for (int c = 0; c < 4; c++)
                    if (bus_addr == 8'h14 + 8'(2*c)) begin
                        m_pre[c] = int'(bus_wdata & 16'h0FFF);
                        if (!m_buf) m_act[c] = m_pre[c];
                    end
                if (bus_addr == 8'h12)
                    for (int c = 0; c < 4; c++) begin
                        m_spol[c]  = bus_wdata[7 - c];
                        m_sgain[c] = bus_wdata[11 - c];
                        if (!m_buf) begin
                            m_apol[c] = m_spol[c]; m_again[c] = m_sgain[c];
                        end
                    end
                if (bus_addr == 8'h02) begin
                    m_en = bus_wdata[1]; m_buf = bus_wdata[0];
                end
            end
            m_rdq = bus_rd;
        end
    end

    // Compare the design against the model on every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < 4; c++) chk("R2 model code", code_of(c), exp_code(c));
            chk("R5 model bipolar", int'(dac_bipolar), pack4(m_apol[0], m_apol[1], m_apol[2], m_apol[3]));
            chk("R5 model gain", int'(dac_gain_hi), pack4(m_again[0], m_again[1], m_again[2], m_again[3]));
            chk("R8 model enable", int'(dac_enable), int'(m_en));
            chk("R8 model buffered", int'(dac_buffered), int'(m_buf));
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, input int cycles);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        repeat (cycles) @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int c = 0; c < 4; c++) chk("R1 reset code", code_of(c), 32'h800);
        chk("R1 reset range", int'({dac_bipolar, dac_gain_hi}), 0);
        chk("R1 reset ctrl", int'({dac_enable, dac_buffered}), 0);

        // R8: control bits
        do_write(8'h02, 16'h0003);
        chk("R8 enable+buffered", int'({dac_enable, dac_buffered}), 3);

        // R2: buffered staging
        do_write(8'h14, 16'hF123);
        do_write(8'h16, 16'h0456);
        do_write(8'h18, 16'h0789);
        do_write(8'h1A, 16'h0ABC);
        chk("R2 staged A not visible", code_of(0), 0);
        chk("R2 staged D not visible", code_of(3), 0);
        do_read(8'h02, 1);
        chk("R2 commit A", code_of(0), 32'h123);
        chk("R2 commit B", code_of(1), 32'h456);
        chk("R2 commit C", code_of(2), 32'h789);
        chk("R2 commit D", code_of(3), 32'hABC);

        // R6: held read transfers once only
        @(negedge clk);
        bus_addr = 8'h02; bus_rd = 1'b1;
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 16'h0777; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h02;
        repeat (3) @(negedge clk);
        chk("R6 held read no repeat", code_of(0), 32'h123);
        bus_rd = 1'b0;
        @(negedge clk);
        chk("R6 after release", code_of(0), 32'h123);
        do_read(8'h02, 1);
        chk("R2 second commit A", code_of(0), 32'h777);

        // R8: read elsewhere transfers nothing
        do_write(8'h14, 16'h0111);
        do_read(8'h04, 2);
        chk("R8 other read no commit", code_of(0), 32'h777);
        do_read(8'h12, 1);
        chk("R8 config read no data commit", code_of(0), 32'h777);

        // R5: configuration staging and bit mapping
        do_write(8'h12, 16'h0880);
        chk("R5 shadow not visible", int'(dac_bipolar), 0);
        do_read(8'h12, 1);
        chk("R5 channel A bipolar", int'(dac_bipolar), 4'b0001);
        chk("R5 channel A gain", int'(dac_gain_hi), 4'b0001);
        do_write(8'h12, 16'h0350);
        do_read(8'h12, 1);
        chk("R5 B,D bipolar", int'(dac_bipolar), 4'b1010);
        chk("R5 C,D gain", int'(dac_gain_hi), 4'b1100);

        // R4: disable shows mid-scale, values retained
        do_write(8'h02, 16'h0001);
        for (int c = 0; c < 4; c++) chk("R4 disabled midscale", code_of(c), 32'h800);
        do_write(8'h02, 16'h0003);
        chk("R4 retained B", code_of(1), 32'h456);

        // R3: unbuffered direct write
        do_write(8'h02, 16'h0002);
        do_write(8'h18, 16'hEABC);
        chk("R3 direct C", code_of(2), 32'hABC);
        do_write(8'h12, 16'h0020);
        chk("R5 unbuffered direct bipolar", int'(dac_bipolar), 4'b0100);

        // R8: other control bits ignored
        do_write(8'h02, 16'hFFFC);
        chk("R8 upper bits ignored", int'({dac_enable, dac_buffered}), 0);

        // R7: zero writes clear everything
        do_write(8'h02, 16'h0003);
        do_write(8'h12, 16'hFFFF);
        do_read(8'h12, 1);
        chk("R7 setup all set", int'(dac_bipolar), 4'hF);
        do_write(8'h02, 16'h0000);
        do_write(8'h12, 16'h0000);
        chk("R7 unipolar", int'(dac_bipolar), 0);
        chk("R7 low gain", int'(dac_gain_hi), 0);
        chk("R7 disabled", int'(dac_enable), 0);
        chk("R7 midscale", code_of(3), 32'h800);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule